// File: doc/BRIEF.md
# Diagonal Half-Sample Luma Interpolator (4x4)

This block computes a 4x4 patch of 8-bit luma pixels at the position that lies half a sample to the right of and half a sample below each integer pixel. A reference window of 9x9 unsigned 8-bit pixels enters one row per cycle on a valid/ready stream. Each accepted row goes through a horizontal six-tap filter with weights 1, -5, 20, 20, -5, 1. That filter gives four 16-bit intermediate values, which are stored in a local 9-row by 4-column buffer.

A constant bias is applied in the horizontal pass so that every intermediate value stays positive. When all nine rows are stored, the same six-tap filter runs down each intermediate column. A single subtraction then removes the accumulated bias and adds the rounding term at the same time. The result is saturated, shifted right by ten bits and sent out.

The sixteen output pixels leave in raster order on a second valid/ready stream. The final pixel carries a last flag. After that pixel is accepted, the block takes a new window.

Top module: `diag_halfpel_interp`

## Requirements
- R1: After synchronous active-high reset, inReady is 1 and outValid is 0.
- R2: Exactly nine row words are accepted per block. From the cycle after the ninth accepted row, inReady is 0 and outValid is 1.
- R3: The row word packs pixel column j (0..8) in bits [8j+7:8j]. Output pixel (row r, column c) is computed in two steps. First, H(y,c) = P(y,c) - 5P(y,c+1) + 20P(y,c+2) + 20P(y,c+3) - 5P(y,c+4) + P(y,c+5). Second, V = H(r,c) - 5H(r+1,c) + 20H(r+2,c) + 20H(r+3,c) - 5H(r+4,c) + H(r+5,c). The pixel value is (V + 512) >> 10, using floor division.
- R4: A result below 0 is output as 0. A result above 255 is output as 255.
- R5: The sixteen pixels leave in order r*4 + c, with row 0 first and column 0 first. outLast is 1 only on the sixteenth pixel.
- R6: While outValid is 1 and outReady is 0, outPixel and outLast stay stable and outValid stays 1.
- R7: Rows offered during the output phase are not accepted (inReady is 0). They do not change any output pixel.
- R8: A new block starts only after the sixteenth pixel is accepted. In the next cycle, outValid is 0 and inReady is 1.
- R9: Every horizontal intermediate, including its bias of 16*255, lies between 1530 and 14790 and fits in 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Row word offered |
| inReady | output | 1 | Block takes a row this cycle |
| inRow | input | 72 | Nine pixels, leftmost in the least significant byte |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Sink takes the pixel |
| outPixel | output | 8 | Interpolated pixel |
| outLast | output | 1 | Marks the sixteenth pixel of the block |

## Verification
The bench uses windows that drive the filter to both clipping rails. A centred bright square pushes the vertical sum well beyond the 18-bit range, and narrow stripes on the negative taps make it negative. A design that wraps instead of saturating would show large wrong values at these points. The bench also checks rounding against an independent integer model; a wrong bias constant would shift every pixel by a fixed amount. Random output backpressure and junk rows offered during the output phase would show a design that drops or repeats pixels under stall, or one that takes extra rows into its buffer.

// File: rtl/diag_interp_pkg.sv
package diag_interp_pkg;
  // Geometry
  parameter int PIX_W = 8;
  parameter int WIN   = 9;                 // window rows and columns
  parameter int BLK   = 4;                 // output block edge
  parameter int TAPS  = 6;
  parameter int INT_W = 16;                // stored intermediate width
  parameter int ACC_W = 22;                // signed accumulator width
  parameter int FRAC  = 5;                 // log2 of the kernel gain
  // Derived
  parameter int SHIFT    = 2 * FRAC;
  parameter int SAT_W    = SHIFT + PIX_W;
  parameter int PIX_MAX  = (1 << PIX_W) - 1;
  parameter int BIAS     = PIX_MAX;
  parameter int HALF_OFF = BIAS * 16;                    // bias carried per intermediate
  parameter int FINAL_OFF = HALF_OFF * (1 << FRAC) - (1 << (SHIFT - 1));
  parameter int H_MIN    = HALF_OFF - 10 * PIX_MAX;
  parameter int H_MAX    = HALF_OFF + 42 * PIX_MAX;
  parameter int ROW_W    = $clog2(WIN + 1);
  parameter int IDX_W    = $clog2(BLK * BLK);
  parameter int POS_W    = $clog2(BLK);

  typedef enum logic {ST_LOAD, ST_EMIT} dipState_t;

  typedef struct packed {
    logic             rowWrite;
    logic [ROW_W-1:0] rowIdx;
    logic [POS_W-1:0] outRow;
    logic [POS_W-1:0] outCol;
  } dipCtrl_t;

  function automatic logic signed [ACC_W-1:0] sixTap(
    input logic signed [ACC_W-1:0] a, input logic signed [ACC_W-1:0] b,
    input logic signed [ACC_W-1:0] c, input logic signed [ACC_W-1:0] d,
    input logic signed [ACC_W-1:0] e, input logic signed [ACC_W-1:0] f);
    logic signed [ACC_W-1:0] inner, outer;
    inner = c + d;
    outer = b + e;
    return a + f + (inner <<< 4) + (inner <<< 2) - (outer <<< 2) - outer;
  endfunction
endpackage

// File: rtl/dip_control.sv
module dip_control
  import diag_interp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output logic     inReady,
  output logic     outValid,
  input  logic     outReady,
  output logic     outLast,
  output dipCtrl_t ctrl
);
  dipState_t        state;
  logic [ROW_W-1:0] rowCnt;
  logic [IDX_W-1:0] outIdx;
  logic             rowTake, pixTake;

  assign inReady  = (state == ST_LOAD);
  assign outValid = (state == ST_EMIT);
  assign outLast  = outValid && (outIdx == IDX_W'(BLK * BLK - 1));
  assign rowTake  = inValid && inReady;
  assign pixTake  = outValid && outReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_LOAD;
      rowCnt <= '0;
      outIdx <= '0;
    end else begin
      case (state)
        ST_LOAD: if (rowTake) begin
          if (rowCnt == ROW_W'(WIN - 1)) begin
            rowCnt <= '0;
            state  <= ST_EMIT;
          end else begin
            rowCnt <= rowCnt + 1'b1;
          end
        end
        ST_EMIT: if (pixTake) begin
          if (outLast) begin
            outIdx <= '0;
            state  <= ST_LOAD;
          end else begin
            outIdx <= outIdx + 1'b1;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  always_comb begin
    ctrl.rowWrite = rowTake;
    ctrl.rowIdx   = rowCnt;
    ctrl.outRow   = outIdx[IDX_W-1:POS_W];
    ctrl.outCol   = outIdx[POS_W-1:0];
  end

  // R2: the ninth accepted row closes the input phase
  a_r2_ninth_row_closes: assert property (@(posedge clk) disable iff (rst)
    (rowTake && rowCnt == ROW_W'(WIN - 1)) |=> (!inReady && outValid));

  // R6: a stalled pixel stays put
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outIdx) && $stable(outLast)));

  // R8: acceptance of the last pixel reopens the input
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    (pixTake && outLast) |=> (inReady && !outValid));
endmodule

// File: rtl/dip_datapath.sv
module dip_datapath
  import diag_interp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  dipCtrl_t               ctrl,
  input  logic [WIN*PIX_W-1:0]   rowData,
  output logic [PIX_W-1:0]       pixel
);
  logic [INT_W-1:0]        interBuf [WIN][BLK];
  logic signed [ACC_W-1:0] hSum [BLK];
  logic signed [ACC_W-1:0] vSum, vAdj;
  logic signed [ACC_W-1:0] vTap [TAPS];
  logic signed [ACC_W-1:0] satVal;

  function automatic logic signed [ACC_W-1:0] pixAt(input logic [WIN*PIX_W-1:0] w, input int j, input logic biased);
    logic signed [ACC_W-1:0] v;
    v = signed'({{(ACC_W-PIX_W){1'b0}}, w[j*PIX_W +: PIX_W]});
    return biased ? v + ACC_W'(BIAS) : v;
  endfunction

  // Horizontal pass: bias on taps 0, 2 and 4 (net gain 16)
  for (genvar k = 0; k < BLK; k++) begin : g_hor
    always_comb begin
      hSum[k] = sixTap(pixAt(rowData, k, 1'b1), pixAt(rowData, k + 1, 1'b0),
                       pixAt(rowData, k + 2, 1'b1), pixAt(rowData, k + 3, 1'b0),
                       pixAt(rowData, k + 4, 1'b1), pixAt(rowData, k + 5, 1'b0));
    end
    always_ff @(posedge clk) begin
      if (ctrl.rowWrite) interBuf[ctrl.rowIdx][k] <= hSum[k][INT_W-1:0];
    end
    // R9: intermediate stays inside its biased range
    a_r9_inter_range: assert property (@(posedge clk) disable iff (rst)
      ctrl.rowWrite |-> (hSum[k] >= ACC_W'(H_MIN) && hSum[k] <= ACC_W'(H_MAX)));
  end

  // Vertical pass over the selected column
  for (genvar t = 0; t < TAPS; t++) begin : g_ver
    always_comb begin
      vTap[t] = signed'({{(ACC_W-INT_W){1'b0}},
                         interBuf[ROW_W'(ctrl.outRow) + ROW_W'(t)][ctrl.outCol]});
    end
  end

  always_comb begin
    vSum = sixTap(vTap[0], vTap[1], vTap[2], vTap[3], vTap[4], vTap[5]);
    vAdj = vSum - ACC_W'(FINAL_OFF);
    if (vAdj < 0)
      satVal = '0;
    else if (vAdj > ACC_W'((1 << SAT_W) - 1))
      satVal = ACC_W'((1 << SAT_W) - 1);
    else
      satVal = vAdj;
    pixel = PIX_W'(satVal >>> SHIFT);
  end

  // R4: a negative adjusted sum yields a zero pixel
  a_r4_low_clip: assert property (@(posedge clk) disable iff (rst)
    (vAdj < 0) |-> (pixel == '0));
endmodule

// File: rtl/diag_halfpel_interp.sv
module diag_halfpel_interp
  import diag_interp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [WIN*PIX_W-1:0] inRow,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [PIX_W-1:0]     outPixel,
  output logic                 outLast
);
  dipCtrl_t ctrl;

  dip_control u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outLast(outLast), .ctrl(ctrl)
  );

  dip_datapath u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .rowData(inRow), .pixel(outPixel)
  );

  // R7: input and output phases never overlap
  a_r7_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(inReady && outValid));

  // R6: stalled pixel value does not move
  a_r6_pixel_stable: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> $stable(outPixel));

  // R5: last flag only with a valid pixel
  a_r5_last_valid: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid);
endmodule

// File: tb/tb_diag_halfpel_interp.sv
`timescale 1ns/1ps
module tb_diag_halfpel_interp;
  localparam real CLK_NS = 4.0;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic        inReady;
  logic [71:0] inRow;
  logic        outValid;
  logic        outReady;
  logic [7:0]  outPixel;
  logic        outLast;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int win [9][9];
  int expd [16];

  always #(CLK_NS / 2) clk = ~clk;

  diag_halfpel_interp dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inRow(inRow),
    .outValid(outValid), .outReady(outReady), .outPixel(outPixel), .outLast(outLast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tap6(input int a, input int b, input int c, input int d, input int e, input int f);
    return a - 5 * b + 20 * c + 20 * d - 5 * e + f;
  endfunction

  // R3/R4 reference model
  task automatic model();
    int h [9][4];
    for (int y = 0; y < 9; y++)
      for (int c = 0; c < 4; c++)
        h[y][c] = tap6(win[y][c], win[y][c+1], win[y][c+2], win[y][c+3], win[y][c+4], win[y][c+5]);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        int v;
        v = tap6(h[r][c], h[r+1][c], h[r+2][c], h[r+3][c], h[r+4][c], h[r+5][c]) + 512;
        if (v < 0) v = 0;
        else v = v >>> 10;
        if (v > 255) v = 255;
        expd[r*4+c] = v;
      end
  endtask

  task automatic loadBlock();
    for (int y = 0; y < 9; y++) begin
      for (int j = 0; j < 9; j++) inRow[j*8 +: 8] = 8'(win[y][j]);
      inValid = 1'b1;
      check(inReady == 1'b1, "R2 ready during load", int'(inReady), 1);
      @(posedge clk); @(negedge clk);
    end
    inValid = 1'b0;
    check(inReady == 1'b0 && outValid == 1'b1, "R2 after ninth row", int'(inReady), 0);
  endtask

  // stallMask bit i: hold pixel i one cycle; junk: offer rows during output (R7)
  task automatic drain(input logic [15:0] stallMask, input bit junk, input string tag);
    model();
    for (int i = 0; i < 16; i++) begin
      if (junk) begin inValid = 1'b1; inRow = {9{8'hA5}} ^ 72'(i); end
      if (stallMask[i]) begin
        int held;
        outReady = 1'b0;
        held = int'(outPixel);
        @(posedge clk); @(negedge clk);
        check(outValid && int'(outPixel) == held, "R6 stall hold", int'(outPixel), held);
      end
      outReady = 1'b1;
      check(outValid == 1'b1, "R5 valid during output", int'(outValid), 1);
      if (junk) check(inReady == 1'b0, "R7 no input taken", int'(inReady), 0);
      check(int'(outPixel) == expd[i], tag, int'(outPixel), expd[i]);
      check(outLast == (i == 15), "R5 last flag", int'(outLast), int'(i == 15));
      @(posedge clk); @(negedge clk);
    end
    inValid  = 1'b0;
    outReady = 1'b0;
    check(outValid == 1'b0 && inReady == 1'b1, "R8 restart after last", int'(inReady), 1);
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R1 inReady after reset", int'(inReady), 1);
  endtask

  task automatic testUniform();
    for (int y = 0; y < 9; y++) for (int x = 0; x < 9; x++) win[y][x] = 128;
    loadBlock();
    drain(16'h0000, 1'b0, "R3 uniform");
  endtask

  task automatic testRamp();
    for (int y = 0; y < 9; y++) for (int x = 0; x < 9; x++) win[y][x] = (x * 23 + y * 11) % 256;
    loadBlock();
    drain(16'h0000, 1'b0, "R3 ramp");
  endtask

  task automatic testHighClip();
    for (int y = 0; y < 9; y++) for (int x = 0; x < 9; x++)
      win[y][x] = (x >= 2 && x <= 3 && y >= 2 && y <= 3) ? 255 : 0;
    loadBlock();
    model();
    check(expd[0] == 255, "R4 high clip model", expd[0], 255);
    drain(16'h0000, 1'b0, "R4 high clip");
  endtask

  task automatic testLowClip();
    for (int y = 0; y < 9; y++) for (int x = 0; x < 9; x++)
      win[y][x] = (x == 1 || x == 4) ? 255 : 0;
    loadBlock();
    model();
    check(expd[0] == 0, "R4 low clip model", expd[0], 0);
    drain(16'h0000, 1'b0, "R4 low clip");
  endtask

  task automatic testStallAndJunk();
    for (int y = 0; y < 9; y++) for (int x = 0; x < 9; x++) win[y][x] = (x * x * 7 + y * 31 + 5) % 256;
    loadBlock();
    drain(16'b1010_0110_0011_1001, 1'b1, "R7 pixel with junk rows");
  endtask

  task automatic testBackToBack();
    for (int y = 0; y < 9; y++) for (int x = 0; x < 9; x++) win[y][x] = ((x + y) % 2) ? 200 : 17;
    loadBlock();
    drain(16'h8001, 1'b0, "R3 checker");
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; outReady = 1'b0; inRow = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testUniform();
    testRamp();
    testHighClip();
    testLowClip();
    testStallAndJunk();
    testBackToBack();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule